// File: doc/BRIEF.md
# MDIO Management Transaction Master

This block carries out a single read or write to a PHY register over the two-wire serial management bus of an Ethernet link. A configuration-side controller provides a command: a PHY address, a register address, 16 bits of write data, a one-bit opcode and a go strobe. Go stays asserted until the block reports completion. The block then generates the management clock and drives the data line. The data line is modelled as a separate output, output-enable and input so that an external pull-up and pad can build the open bidirectional wire.

Each transaction is one 64-bit frame, sent in this order:
- 32 bits of preamble, all ones;
- the start pattern `01`;
- the opcode, `10` for a read or `01` for a write;
- the PHY address, MSB first;
- the register address, MSB first;
- a two-bit turnaround;
- 16 data bits.

On a write the block drives every bit. On a read the block releases the line from the turnaround onward and captures the PHY's answer. When the frame is over, the block emits one clean single-cycle done pulse. A pulse synchroniser can carry this pulse into another clock domain. The error flag and the read data are updated on that same cycle, so the receiver can latch them on the pulse.

Top module: `mdio_txn_master`

## Requirements
- R1: After reset the management clock is low, the data line is released (output-enable 0, output 1), done is low, the error flag is 0 and the read data is 0.
- R2: While a frame runs, the management clock has a period of exactly `DIV` system clocks, half high and half low. Between frames it stays low. The default `DIV` of 40 gives 2.5 MHz from a 100 MHz clock.
- R3: Every frame has exactly 64 management-clock rising edges. The 46 bits before the turnaround are driven as follows:
  - 32 ones;
  - start `01`;
  - opcode `10` when `cmd_write`=0 (read) or `01` when `cmd_write`=1 (write);
  - the 5-bit PHY address, MSB first;
  - the 5-bit register address, MSB first.
- R4: On a write the block drives the turnaround as `10`, then the 16 write-data bits MSB first. Output-enable stays 1 for all 64 bits.
- R5: On a read, output-enable is 0 from the first turnaround bit to the end of the frame. The 16 bits sampled after the turnaround are reported MSB first on `rd_data`, even when the error flag is set. A write reports `rd_data` = 0. `rd_data` changes only in the cycle where done is high.
- R6: `xfer_err` is 1 when the line is sampled high at the second turnaround bit of a read. It is 0 after a write and after a read that a PHY answered. It changes only in the cycle where done is high.
- R7: Each transaction ends with exactly one done pulse, one system clock wide, issued after the last bit. In that cycle the management clock is low and the line is released.
- R8: A transaction launches only when `cmd_go` is high after having been seen low since the previous launch. A go held high after done does not start another frame.
- R9: The command fields are captured at launch. Changing them while a frame runs has no effect on the frame or on the result.
- R10: The data output and output-enable change only while the management clock is low, so they never change while it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_go | input | 1 | Launch strobe, held until done |
| cmd_write | input | 1 | Opcode: 1 write, 0 read |
| cmd_phy | input | 5 | PHY address |
| cmd_reg | input | 5 | PHY register address |
| cmd_wdata | input | 16 | Write data |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data line output value |
| mdio_oe | output | 1 | Data line output enable |
| mdio_i | input | 1 | Data line input value |
| xfer_done | output | 1 | Single-cycle completion pulse |
| xfer_err | output | 1 | No-answer error, valid with done |
| rd_data | output | 16 | Read data, valid with done |

## Verification
The bench builds the block with `DIV` = 4. Each frame then lasts about 256 system clocks, which keeps many complete read and write frames affordable. With this setting the exact clock-period check and the check that the line is stable while the clock is high exercise the same divider arithmetic as the default. The bench contains a PHY model that answers reads or stays silent, so it reaches both error outcomes and the all-ones read data of an unanswered read. Directed runs hold go high past done and change the command fields mid-frame.

// File: rtl/mdm_pkg.sv
package mdm_pkg;
  typedef enum logic {
    MDM_IDLE  = 1'b0,
    MDM_SHIFT = 1'b1
  } mdm_state_e;

  localparam logic [1:0] MDM_SOF   = 2'b01;
  localparam logic [1:0] MDM_OP_RD = 2'b10;
  localparam logic [1:0] MDM_OP_WR = 2'b01;
  localparam logic [1:0] MDM_TA_WR = 2'b10;
endpackage

// File: rtl/mdm_frame.sv
module mdm_frame #(
  parameter int PRE_LEN = 32,
  parameter int PHY_W   = 5,
  parameter int REG_W   = 5,
  parameter int DATA_W  = 16,
  localparam int FRAME_LEN = PRE_LEN + 4 + PHY_W + REG_W + 2 + DATA_W
) (
  input  logic                 wr,
  input  logic [PHY_W-1:0]     phy,
  input  logic [REG_W-1:0]     rg,
  input  logic [DATA_W-1:0]    wdata,
  output logic [FRAME_LEN-1:0] frame
);
  import mdm_pkg::*;

  // Read frames carry zeros in the turnaround/data slots; the line is released there.
  always_comb begin
    frame = {{PRE_LEN{1'b1}},
             MDM_SOF,
             (wr ? MDM_OP_WR : MDM_OP_RD),
             phy,
             rg,
             (wr ? MDM_TA_WR : 2'b00),
             (wr ? wdata : {DATA_W{1'b0}})};
  end
endmodule

// File: rtl/mdm_clkgen.sv
module mdm_clkgen #(
  parameter int DIV = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic mdc,
  output logic rise_tk,
  output logic fall_tk
);
  localparam int HALF = (DIV / 2 < 1) ? 1 : DIV / 2;
  localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [CW-1:0] CLIM = CW'(HALF - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          mdc_q, mdc_d;
  logic          tick;

  assign tick    = run && (cnt_q == CLIM);
  assign rise_tk = tick && !mdc_q;
  assign fall_tk = tick && mdc_q;
  assign mdc     = mdc_q;

  always_comb begin
    cnt_d = cnt_q;
    mdc_d = mdc_q;
    if (!run) begin
      cnt_d = '0;
      mdc_d = 1'b0;
    end else if (tick) begin
      cnt_d = '0;
      mdc_d = !mdc_q;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      mdc_q <= mdc_d;
    end
  end

  // R2: the clock edge only moves when the half-period count is complete
  p_toggle_at_limit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mdc_q != $past(mdc_q)) |-> ($past(cnt_q) == CLIM));

  // R2: the clock parks low whenever no frame is running
  p_idle_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !mdc_q);
endmodule

// File: rtl/mdm_seq.sv
module mdm_seq #(
  parameter int PRE_LEN = 32,
  parameter int PHY_W   = 5,
  parameter int REG_W   = 5,
  parameter int DATA_W  = 16,
  localparam int FRAME_LEN = PRE_LEN + 4 + PHY_W + REG_W + 2 + DATA_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cmd_go,
  input  logic                 cmd_write,
  input  logic [FRAME_LEN-1:0] frame,
  input  logic                 mdc,
  input  logic                 rise_tk,
  input  logic                 fall_tk,
  input  logic                 mdio_i,
  output logic                 run,
  output logic                 mdio_o,
  output logic                 mdio_oe,
  output logic                 xfer_done,
  output logic                 xfer_err,
  output logic [DATA_W-1:0]    rd_data
);
  import mdm_pkg::*;

  localparam int IW     = $clog2(FRAME_LEN);
  localparam int TA_POS = PRE_LEN + 4 + PHY_W + REG_W;
  localparam logic [IW-1:0] LAST_IX  = IW'(FRAME_LEN - 1);
  localparam logic [IW-1:0] TA_M1_IX = IW'(TA_POS - 1);
  localparam logic [IW-1:0] TA2_IX   = IW'(TA_POS + 1);
  localparam logic [IW-1:0] DAT_IX   = IW'(TA_POS + 2);

  mdm_state_e            state_q, state_d;
  logic [IW-1:0]         idx_q, idx_d;
  logic [FRAME_LEN-1:0]  tx_q, tx_d;
  logic                  wr_q, wr_d;
  logic [DATA_W-1:0]     rx_q, rx_d;
  logic                  etmp_q, etmp_d;
  logic                  oe_q, oe_d;
  logic                  o_q, o_d;
  logic                  done_q, done_d;
  logic                  err_q, err_d;
  logic [DATA_W-1:0]     rd_q, rd_d;
  logic                  armed_q, armed_d;
  logic                  launch;

  assign launch = (state_q == MDM_IDLE) && cmd_go && armed_q;

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    tx_d    = tx_q;
    wr_d    = wr_q;
    rx_d    = rx_q;
    etmp_d  = etmp_q;
    oe_d    = oe_q;
    o_d     = o_q;
    done_d  = 1'b0;
    err_d   = err_q;
    rd_d    = rd_q;
    armed_d = armed_q;

    if (launch)       armed_d = 1'b0;
    else if (!cmd_go) armed_d = 1'b1;

    unique case (state_q)
      MDM_IDLE: begin
        if (launch) begin
          state_d = MDM_SHIFT;
          idx_d   = '0;
          tx_d    = frame;
          wr_d    = cmd_write;
          rx_d    = '0;
          etmp_d  = 1'b0;
          oe_d    = 1'b1;
          o_d     = frame[FRAME_LEN-1];
        end
      end
      MDM_SHIFT: begin
        if (rise_tk && !wr_q) begin
          if (idx_q == TA2_IX) etmp_d = mdio_i;
          if (idx_q >= DAT_IX) rx_d = {rx_q[DATA_W-2:0], mdio_i};
        end
        if (fall_tk) begin
          if (idx_q == LAST_IX) begin
            state_d = MDM_IDLE;
            oe_d    = 1'b0;
            o_d     = 1'b1;
            done_d  = 1'b1;
            err_d   = etmp_q;
            rd_d    = rx_q;
          end else begin
            idx_d = idx_q + 1'b1;
            tx_d  = {tx_q[FRAME_LEN-2:0], 1'b0};
            o_d   = tx_q[FRAME_LEN-2];
            oe_d  = wr_q || (idx_q < TA_M1_IX);
          end
        end
      end
      default: state_d = MDM_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= MDM_IDLE;
      idx_q   <= '0;
      tx_q    <= '0;
      wr_q    <= 1'b0;
      rx_q    <= '0;
      etmp_q  <= 1'b0;
      oe_q    <= 1'b0;
      o_q     <= 1'b1;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      rd_q    <= '0;
      armed_q <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      tx_q    <= tx_d;
      wr_q    <= wr_d;
      rx_q    <= rx_d;
      etmp_q  <= etmp_d;
      oe_q    <= oe_d;
      o_q     <= o_d;
      done_q  <= done_d;
      err_q   <= err_d;
      rd_q    <= rd_d;
      armed_q <= armed_d;
    end
  end

  assign run       = (state_q == MDM_SHIFT);
  assign mdio_o    = o_q;
  assign mdio_oe   = oe_q;
  assign xfer_done = done_q;
  assign xfer_err  = err_q;
  assign rd_data   = rd_q;

  // R7: completion is a single-cycle pulse
  p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |=> !xfer_done);

  // R7: at completion the clock is low and the line released
  p_done_released_r7: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |-> (!mdc && !mdio_oe));

  // R6: the error flag moves only together with done
  p_err_with_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(xfer_err) |-> xfer_done);

  // R5: read data moves only together with done
  p_rdata_with_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rd_data) |-> xfer_done);

  // R10: the line holds still while the management clock is high
  p_stable_high_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mdc && $past(mdc)) |-> ($stable(mdio_o) && $stable(mdio_oe)));

  // R8: a frame starts only while go is asserted
  p_launch_go_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run) |-> $past(cmd_go));
endmodule

// File: rtl/mdio_txn_master.sv
module mdio_txn_master #(
  parameter int DIV     = 40,
  parameter int PRE_LEN = 32,
  parameter int PHY_W   = 5,
  parameter int REG_W   = 5,
  parameter int DATA_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_go,
  input  logic              cmd_write,
  input  logic [PHY_W-1:0]  cmd_phy,
  input  logic [REG_W-1:0]  cmd_reg,
  input  logic [DATA_W-1:0] cmd_wdata,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic              mdio_i,
  output logic              xfer_done,
  output logic              xfer_err,
  output logic [DATA_W-1:0] rd_data
);
  localparam int FRAME_LEN = PRE_LEN + 4 + PHY_W + REG_W + 2 + DATA_W;

  logic [FRAME_LEN-1:0] frame;
  logic                 run, rise_tk, fall_tk;

  mdm_frame #(
    .PRE_LEN(PRE_LEN), .PHY_W(PHY_W), .REG_W(REG_W), .DATA_W(DATA_W)
  ) u_frame (
    .wr    (cmd_write),
    .phy   (cmd_phy),
    .rg    (cmd_reg),
    .wdata (cmd_wdata),
    .frame (frame)
  );

  mdm_clkgen #(.DIV(DIV)) u_clkgen (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run),
    .mdc     (mdc),
    .rise_tk (rise_tk),
    .fall_tk (fall_tk)
  );

  mdm_seq #(
    .PRE_LEN(PRE_LEN), .PHY_W(PHY_W), .REG_W(REG_W), .DATA_W(DATA_W)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_go    (cmd_go),
    .cmd_write (cmd_write),
    .frame     (frame),
    .mdc       (mdc),
    .rise_tk   (rise_tk),
    .fall_tk   (fall_tk),
    .mdio_i    (mdio_i),
    .run       (run),
    .mdio_o    (mdio_o),
    .mdio_oe   (mdio_oe),
    .xfer_done (xfer_done),
    .xfer_err  (xfer_err),
    .rd_data   (rd_data)
  );
endmodule

// File: tb/mdio_txn_master_bench.sv
module mdio_txn_master_bench;
  localparam int DIV = 4;
  localparam int TA  = 46;

  typedef struct packed {
    logic        wr;
    logic [4:0]  phy;
    logic [4:0]  rg;
    logic [15:0] wd;
    logic        ans;
    logic [15:0] resp;
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{1'b1, 5'h01, 5'h00, 16'h1234, 1'b1, 16'h0000},
    '{1'b0, 5'h1F, 5'h1F, 16'h0000, 1'b1, 16'hA5C3},
    '{1'b0, 5'h00, 5'h02, 16'h0000, 1'b0, 16'h0000},
    '{1'b1, 5'h10, 5'h15, 16'hFFFF, 1'b1, 16'h0000},
    '{1'b0, 5'h0A, 5'h05, 16'h0000, 1'b1, 16'h0001},
    '{1'b1, 5'h15, 5'h0A, 16'h0000, 1'b1, 16'h0000}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_go = 1'b0, cmd_write = 1'b0;
  logic [4:0]  cmd_phy = '0, cmd_reg = '0;
  logic [15:0] cmd_wdata = '0;
  logic        mdc, mdio_o, mdio_oe, mdio_i, xfer_done, xfer_err;
  logic [15:0] rd_data;

  int nchk = 0, nerr = 0;
  int n = 0, base = 0;
  int done_cnt = 0, dbl_cnt = 0, per_bad = 0, stab_bad = 0;
  logic done_prev = 1'b0;
  logic answer = 1'b1;
  logic [15:0] resp = '0;
  logic cap_o [64];
  logic cap_oe [64];
  logic last_o = 1'b1, last_oe = 1'b0;
  longint t_last = 0;

  always #5 clk = ~clk;

  mdio_txn_master #(.DIV(DIV)) u_mdio_txn_master (
    .clk(clk), .rst_n(rst_n), .cmd_go(cmd_go), .cmd_write(cmd_write),
    .cmd_phy(cmd_phy), .cmd_reg(cmd_reg), .cmd_wdata(cmd_wdata),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i),
    .xfer_done(xfer_done), .xfer_err(xfer_err), .rd_data(rd_data)
  );

  // PHY model: value presented before rising edge number (n - base)
  always_comb begin
    if ((n - base) == TA + 1)
      mdio_i = !answer;
    else if ((n - base) >= TA + 2 && (n - base) < 64)
      mdio_i = answer ? resp[63 - (n - base)] : 1'b1;
    else
      mdio_i = 1'b1;
  end

  always @(posedge mdc) begin
    if ((n - base) >= 0 && (n - base) < 64) begin
      cap_o[n - base]  = mdio_o;
      cap_oe[n - base] = mdio_oe;
    end
    if ((n - base) > 0 && ($time - t_last) != DIV * 10) per_bad++;
    t_last  = $time;
    last_o  = mdio_o;
    last_oe = mdio_oe;
    n <= n + 1;
  end

  always @(posedge clk) begin
    if (xfer_done) done_cnt <= done_cnt + 1;
    if (xfer_done && done_prev) dbl_cnt <= dbl_cnt + 1;
    done_prev <= xfer_done;
  end

  always @(negedge clk) begin
    if (rst_n && mdc && (mdio_o !== last_o || mdio_oe !== last_oe)) stab_bad++;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] exp_frame(input vec_t v);
    return {32'hFFFF_FFFF, 2'b01, (v.wr ? 2'b01 : 2'b10), v.phy, v.rg,
            (v.wr ? 2'b10 : 2'b00), (v.wr ? v.wd : 16'h0)};
  endfunction

  task automatic run_txn(input vec_t v, input bit disturb, input bit hold);
    logic [63:0] ef;
    int hdr_bad, dat_bad, oe_bad, pb0, sb0, dc0, db0, waited, n_end;
    bit got;
    ef = exp_frame(v);
    @(negedge clk);
    cmd_write = v.wr; cmd_phy = v.phy; cmd_reg = v.rg; cmd_wdata = v.wd;
    answer = v.ans; resp = v.resp;
    base = n; pb0 = per_bad; sb0 = stab_bad; dc0 = done_cnt; db0 = dbl_cnt;
    cmd_go = 1'b1;
    got = 0; waited = 0;
    while (!got && waited < 70 * DIV + 50) begin
      @(negedge clk);
      waited++;
      if (disturb && waited == 100) begin
        cmd_write = ~v.wr; cmd_phy = ~v.phy; cmd_reg = ~v.rg; cmd_wdata = ~v.wd;
      end
      if (xfer_done) got = 1;
    end
    chk(got, "R7 done seen", {31'b0, got}, 1);
    chk(!mdc && !mdio_oe, "R7 released at done", {mdc, mdio_oe}, 0);
    chk(rd_data == (v.wr ? 16'h0 : (v.ans ? v.resp : 16'hFFFF)), "R5 read data",
        rd_data, (v.wr ? 16'h0 : (v.ans ? v.resp : 16'hFFFF)));
    chk(xfer_err == (!v.wr && !v.ans), "R6 error flag", xfer_err, (!v.wr && !v.ans));
    chk((n - base) == 64, "R3 rising edge count", n - base, 64);
    hdr_bad = 0; dat_bad = 0; oe_bad = 0;
    for (int k = 0; k < 64; k++) begin
      if (k < TA) begin
        if (cap_o[k] !== ef[63 - k]) hdr_bad++;
        if (cap_oe[k] !== 1'b1) oe_bad++;
      end else if (v.wr) begin
        if (cap_o[k] !== ef[63 - k]) dat_bad++;
        if (cap_oe[k] !== 1'b1) oe_bad++;
      end else begin
        if (cap_oe[k] !== 1'b0) oe_bad++;
      end
    end
    chk(hdr_bad == 0, disturb ? "R9 header under disturb" : "R3 header bits", hdr_bad, 0);
    if (v.wr) chk(dat_bad == 0, "R4 turnaround and write data", dat_bad, 0);
    chk(oe_bad == 0, v.wr ? "R4 output enable" : "R5 line release", oe_bad, 0);
    chk(per_bad == pb0, "R2 clock period", per_bad - pb0, 0);
    chk(stab_bad == sb0, "R10 stable while clock high", stab_bad - sb0, 0);
    repeat (3) @(negedge clk);
    chk(done_cnt == dc0 + 1 && dbl_cnt == db0, "R7 single done pulse", done_cnt - dc0, 1);
    if (hold) begin
      n_end = n; dc0 = done_cnt;
      repeat (600) @(negedge clk);
      chk(n == n_end && done_cnt == dc0 && !mdc, "R8 held go ignored", n - n_end, 0);
    end
    cmd_go = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!mdc && !mdio_oe && mdio_o && !xfer_done, "R1 line and clock at reset",
        {mdc, mdio_oe, mdio_o, xfer_done}, 4'b0010);
    chk(!xfer_err && rd_data == 16'h0, "R1 result at reset", {xfer_err, rd_data}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!mdc, "R2 clock low when idle", mdc, 0);
    for (int i = 0; i < 6; i++) run_txn(VEC[i], 1'b0, 1'b0);
    run_txn('{1'b1, 5'h0C, 5'h13, 16'hC0DE, 1'b1, 16'h0}, 1'b1, 1'b0);
    run_txn('{1'b0, 5'h03, 5'h01, 16'h0, 1'b1, 16'h5A5A}, 1'b1, 1'b0);
    run_txn('{1'b0, 5'h07, 5'h11, 16'h0, 1'b1, 16'h8001}, 1'b0, 1'b1);
    run_txn('{1'b1, 5'h02, 5'h04, 16'h0F0F, 1'b1, 16'h0}, 1'b0, 1'b0);
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    #(200000 * 10);
    nchk++; nerr++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule